// File: doc/BRIEF.md
# Byte-Masked Quadword Store Unit

This unit takes one store request made of a base byte address, a 64-bit source word and a 64-bit select word. It writes into memory only those source bytes whose select byte has its most significant bit set. Every other destination byte is left as it was. The destination is never read. The merge happens entirely through the per-byte enables of a word-wide write port, so the unit has no read path at all.

The memory side is word-aligned. A base address that is not a multiple of the word size spreads the eight source bytes across two adjacent memory words. The unit rotates data and enables into lane position and issues one beat per word that holds at least one selected byte, lower word first. Each beat is held until memory accepts it.

A request whose select word picks no byte still completes with a done pulse, but no write is issued. The same holds for a request that the external fault checker aborts in its acceptance cycle. Address legality stays the job of that checker, even when nothing is written.

Top module: `masked_qword_store`

## Requirements
- R1: Source byte i (bits 8i+7..8i) is selected exactly when select bit 8i+7 is 1. The lower seven bits of each select byte have no effect on what is written.
- R2: Selected source byte i lands at byte address base+i. The write port carries a word address with its three low bits zero, and byte i uses lane (base[2:0]+i) mod 8 of the word holding address base+i.
- R3: A destination byte whose source byte is not selected keeps its previous contents, and every issued beat has at least one enable bit set.
- R4: A request that selects no byte causes no write beat, and done rises in the first cycle after acceptance.
- R5: When the abort input is high in the acceptance cycle, no write beat is issued, and done rises in the first cycle after acceptance.
- R6: While a write beat is offered and memory ready is low, the beat stays offered with address, data and enables unchanged.
- R7: When selected bytes fall into two words, two beats are issued: the lower word first, then the word at address +8. A word with no selected byte gets no beat.
- R8: done is a one-cycle pulse in the cycle after the last write handshake (or as in R4/R5). The request ready is low from acceptance through the done cycle and is never high while a beat is offered.
- R9: During and right after reset, request ready is 1, and both the write valid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_addr | input | 32 | Base byte address |
| req_data | input | 64 | Source word, byte i at bits 8i+7..8i |
| req_mask | input | 64 | Select word, bit 8i+7 selects byte i |
| req_abort | input | 1 | Fault checker veto, sampled at acceptance |
| mem_wr_valid | output | 1 | Write beat offered |
| mem_wr_ready | input | 1 | Memory accepts the beat |
| mem_wr_addr | output | 32 | Word-aligned byte address of the beat |
| mem_wr_data | output | 64 | Lane-aligned write data |
| mem_wr_be | output | 8 | Per-lane byte enables |
| done | output | 1 | Request completed |

## Verification
The embedded assertions watch every cycle for four things: that a stalled beat holds steady, that no beat goes out with empty enables or an unaligned address, that done comes as a single pulse with a valid cause, and that request ready never overlaps a busy unit. An empty or aborted request must finish one cycle later without a write, and this is also checked as a property. Only the bench scenarios can show that the right bytes end up at the right addresses while untouched bytes survive. They also show the beat count and order for bases that straddle a word boundary, and that the low select bits are ignored. A byte-accurate memory model set against reference functions does this, under random memory stalls.

// File: rtl/msq_pkg.sv
package msq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_FIN  = 2'd3
   } msq_state_e;

endpackage

// File: rtl/msq_lane_decode.sv
module msq_lane_decode #(
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] sel_word,
   output logic [LANES-1:0]        lane_en,
   output logic                    any_en
);
   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("msq_lane_decode: LANE_W must be at least 2");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         // the sign bit of each select lane decides
         assign lane_en[g] = sel_word[g*LANE_W + LANE_W - 1];
      end
   endgenerate

   assign any_en = |lane_en;
endmodule

// File: rtl/msq_lane_align.sv
module msq_lane_align #(
   parameter int LANES           = 8,
   parameter int LANE_W          = 8,
   parameter bit ALLOW_UNALIGNED = 1'b1,
   localparam int DW    = LANES * LANE_W,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [DW-1:0]    src_data,
   input  logic [LANES-1:0] src_en,
   input  logic [OFS_W-1:0] ofs,
   output logic [DW-1:0]    lo_data,
   output logic [DW-1:0]    hi_data,
   output logic [LANES-1:0] lo_en,
   output logic [LANES-1:0] hi_en
);
   logic [2*DW-1:0]    wide_data;
   logic [2*LANES-1:0] wide_en;

   generate
      if (ALLOW_UNALIGNED) begin : g_rotate
         always_comb begin
            wide_data = {{DW{1'b0}}, src_data} << (ofs * LANE_W);
            wide_en   = {{LANES{1'b0}}, src_en} << ofs;
         end
      end else begin : g_direct
         logic unused_ofs;
         assign unused_ofs = ^ofs;
         always_comb begin
            wide_data = {{DW{1'b0}}, src_data};
            wide_en   = {{LANES{1'b0}}, src_en};
         end
      end
   endgenerate

   assign lo_data = wide_data[DW-1:0];
   assign hi_data = wide_data[2*DW-1:DW];
   assign lo_en   = wide_en[LANES-1:0];
   assign hi_en   = wide_en[2*LANES-1:LANES];
endmodule

// File: rtl/msq_beat_seq.sv
module msq_beat_seq
   import msq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic abort,
   input  logic acc_lo_any,
   input  logic acc_hi_any,
   input  logic pend_hi,
   input  logic mem_ready,
   output logic is_idle,
   output logic is_lo,
   output logic is_hi,
   output logic is_fin
);
   msq_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) begin
            if (abort || !(acc_lo_any || acc_hi_any)) st_d = ST_FIN;
            else if (acc_lo_any)                      st_d = ST_LO;
            else                                      st_d = ST_HI;
         end
         ST_LO:   if (mem_ready) st_d = pend_hi ? ST_HI : ST_FIN;
         ST_HI:   if (mem_ready) st_d = ST_FIN;
         ST_FIN:  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign is_idle = (st_q == ST_IDLE);
   assign is_lo   = (st_q == ST_LO);
   assign is_hi   = (st_q == ST_HI);
   assign is_fin  = (st_q == ST_FIN);

   // R7: the upper beat is only ever reached from idle or after a lower beat handshake
   a_r7_hi_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (is_hi && !$past(is_hi)) |-> $past((is_idle && accept) || (is_lo && mem_ready)));
endmodule

// File: rtl/masked_qword_store.sv
module masked_qword_store #(
   parameter int ADDR_W          = 32,
   parameter int LANES           = 8,
   parameter int LANE_W          = 8,
   parameter bit ALLOW_UNALIGNED = 1'b1,
   localparam int DW    = LANES * LANE_W,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DW-1:0]     req_data,
   input  logic [DW-1:0]     req_mask,
   input  logic              req_abort,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DW-1:0]     mem_wr_data,
   output logic [LANES-1:0]  mem_wr_be,
   output logic              done
);
   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("masked_qword_store: LANES must be a power of two >= 2");
      end
      if (ADDR_W <= OFS_W + 1) begin : g_bad_addr
         $error("masked_qword_store: ADDR_W too small for the lane count");
      end
   endgenerate

   logic              accept;
   logic [LANES-1:0]  req_en;
   logic              req_any;
   logic [DW-1:0]     al_lo_data, al_hi_data;
   logic [LANES-1:0]  al_lo_en, al_hi_en;
   logic [DW-1:0]     lo_data_q, hi_data_q;
   logic [LANES-1:0]  lo_en_q, hi_en_q;
   logic [ADDR_W-1:0] word_addr_q;
   logic              st_idle, st_lo, st_hi, st_fin;

   msq_lane_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_decode (
      .sel_word (req_mask),
      .lane_en  (req_en),
      .any_en   (req_any)
   );

   msq_lane_align #(.LANES(LANES), .LANE_W(LANE_W), .ALLOW_UNALIGNED(ALLOW_UNALIGNED)) u_align (
      .src_data (req_data),
      .src_en   (req_en),
      .ofs      (req_addr[OFS_W-1:0]),
      .lo_data  (al_lo_data),
      .hi_data  (al_hi_data),
      .lo_en    (al_lo_en),
      .hi_en    (al_hi_en)
   );

   msq_beat_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .abort      (req_abort),
      .acc_lo_any (|al_lo_en),
      .acc_hi_any (|al_hi_en),
      .pend_hi    (|hi_en_q),
      .mem_ready  (mem_wr_ready),
      .is_idle    (st_idle),
      .is_lo      (st_lo),
      .is_hi      (st_hi),
      .is_fin     (st_fin)
   );

   assign req_ready = st_idle;
   assign accept    = req_valid && st_idle;

   // payload capture; an abort clears the enables so nothing can leak out
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_data_q   <= '0;
         hi_data_q   <= '0;
         lo_en_q     <= '0;
         hi_en_q     <= '0;
         word_addr_q <= '0;
      end else if (accept) begin
         lo_data_q   <= al_lo_data;
         hi_data_q   <= al_hi_data;
         lo_en_q     <= req_abort ? '0 : al_lo_en;
         hi_en_q     <= req_abort ? '0 : al_hi_en;
         word_addr_q <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      end
   end

   assign mem_wr_valid = st_lo || st_hi;
   assign mem_wr_addr  = st_hi ? (word_addr_q + ADDR_W'(LANES)) : word_addr_q;
   assign mem_wr_data  = st_hi ? hi_data_q : lo_data_q;
   assign mem_wr_be    = st_hi ? hi_en_q : (st_lo ? lo_en_q : '0);
   assign done         = st_fin;

   // R9: state leaving reset
   a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !mem_wr_valid && !done));

   // R6: a stalled beat is held steady
   a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)
         && $stable(mem_wr_data) && $stable(mem_wr_be)));

   // R3: no beat carries empty enables
   a_r3_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_be != '0));

   // R2: beats use word addresses
   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (mem_wr_addr[OFS_W-1:0] == '0));

   // R4 / R5: empty or vetoed request completes next cycle with no write
   a_r4_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_abort || !req_any)) |=> (done && !mem_wr_valid));

   // R8: done is a single pulse with a cause
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(accept || (mem_wr_valid && mem_wr_ready)));
   a_r8_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && (mem_wr_valid || done)));
endmodule

// File: tb/masked_qword_store_tb.sv
module masked_qword_store_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [63:0] req_data = '0;
   logic [63:0] req_mask = '0;
   logic        req_abort = 1'b0;
   logic        mem_wr_valid;
   logic        mem_wr_ready = 1'b0;
   logic [31:0] mem_wr_addr;
   logic [63:0] mem_wr_data;
   logic [7:0]  mem_wr_be;
   logic        done;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [7:0] mem_dut [0:255];
   logic [7:0] mem_ref [0:255];

   always #5 clk = ~clk;

   masked_qword_store dut_i (
      .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_data, .req_mask,
      .req_abort, .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data,
      .mem_wr_be, .done
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_beats(input int base, input logic [63:0] m, input bit ab);
      bit lo = 0, hi = 0;
      if (ab) return 0;
      for (int i = 0; i < 8; i++)
         if (m[8*i+7]) begin
            if ((base % 8) + i < 8) lo = 1; else hi = 1;
         end
      return int'(lo) + int'(hi);
   endfunction

   function automatic int first_addr(input int base, input logic [63:0] m);
      for (int i = 0; i < 8; i++)
         if (m[8*i+7] && (base % 8) + i < 8) return base - (base % 8);
      return base - (base % 8) + 8;
   endfunction

   task automatic run_txn(input int base, input logic [63:0] d, input logic [63:0] m, input bit ab);
      int beats = 0, last_hs = 0, done_k = 0, stall_bad = 0, busy_bad = 0, mism = 0;
      int addr0 = -1, addr1 = -1, win;
      bit stalled = 0;
      logic [31:0] s_a; logic [63:0] s_d; logic [7:0] s_b;
      @(negedge clk);
      req_valid = 1; req_addr = base; req_data = d; req_mask = m; req_abort = ab;
      @(negedge clk);
      req_valid = 0; req_abort = 0;
      if (!ab) for (int i = 0; i < 8; i++) if (m[8*i+7]) mem_ref[base+i] = d[8*i +: 8];
      for (int k = 1; k < 80; k++) begin
         if (req_ready) busy_bad++;
         if (done) begin done_k = k; break; end
         mem_wr_ready = 0;
         if (mem_wr_valid) begin
            if (stalled && (s_a != mem_wr_addr || s_d != mem_wr_data || s_b != mem_wr_be))
               stall_bad++;
            mem_wr_ready = ($urandom % 3) != 0;
            if (mem_wr_ready) begin
               stalled = 0;
               if (beats == 0) addr0 = int'(mem_wr_addr); else addr1 = int'(mem_wr_addr);
               beats++; last_hs = k;
               for (int l = 0; l < 8; l++)
                  if (mem_wr_be[l] && mem_wr_addr < 256) mem_dut[mem_wr_addr + l] = mem_wr_data[8*l +: 8];
            end else begin
               stalled = 1; s_a = mem_wr_addr; s_d = mem_wr_data; s_b = mem_wr_be;
            end
         end else if (stalled) stall_bad++;
         @(negedge clk);
      end
      mem_wr_ready = 0;
      check(beats == exp_beats(base, m, ab), "R7 beat count", beats, exp_beats(base, m, ab));
      check(done_k == ((beats == 0) ? 1 : last_hs + 1), ab ? "R5 done timing" :
            (beats == 0 ? "R4 done timing" : "R8 done timing"),
            done_k, (beats == 0) ? 1 : last_hs + 1);
      check(stall_bad == 0, "R6 stalled beat changed", stall_bad, 0);
      check(busy_bad == 0, "R8 ready while busy", busy_bad, 0);
      if (beats > 0)
         check(addr0 == first_addr(base, m), "R2 first beat address", addr0, first_addr(base, m));
      if (beats == 2)
         check(addr1 == addr0 + 8, "R7 second beat address", addr1, addr0 + 8);
      win = base - (base % 8);
      for (int j = win; j < win + 16; j++) if (mem_dut[j] !== mem_ref[j]) mism++;
      check(mism == 0, "R1/R2/R3 memory contents", mism, 0);
      @(negedge clk);
      check(done == 0 && req_ready == 1, "R8 done single pulse", {done, req_ready}, 2'b01);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 256; i++) begin
         mem_dut[i] = 8'(i * 37 + 11);
         mem_ref[i] = 8'(i * 37 + 11);
      end
      repeat (3) @(negedge clk);
      check(req_ready == 1 && mem_wr_valid == 0 && done == 0, "R9 in reset",
            {req_ready, mem_wr_valid, done}, 3'b100);
      rst_n = 1;
      @(negedge clk);
      check(req_ready == 1 && mem_wr_valid == 0 && done == 0, "R9 after reset",
            {req_ready, mem_wr_valid, done}, 3'b100);
      // directed corners
      run_txn(16,  64'h8877_6655_4433_2211, 64'hFFFF_FFFF_FFFF_FFFF, 0); // R2 aligned full
      run_txn(40,  64'h0102_0304_0506_0708, 64'h0, 0);                   // R4 empty
      run_txn(64,  64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF, 1); // R5 abort
      run_txn(80,  64'hAAAA_AAAA_AAAA_AAAA, 64'h7F7F_7F7F_7F7F_7F7F, 0); // R1 low bits ignored
      run_txn(101, 64'h1122_3344_5566_7788, 64'h8000_8000_0080_0080, 0); // R3 sparse, R7 split
      run_txn(125, 64'hF1F2_F3F4_F5F6_F7F8, 64'hFFFF_FFFF_FFFF_FFFF, 0); // R7 full split
      run_txn(141, 64'h0000_0000_0000_00C3, 64'h0000_0000_0000_0080, 0); // R7 low only
      run_txn(157, 64'h9900_0000_0000_0000, 64'h8000_0000_0000_0000, 0); // R7 high only
      // random mix
      for (int t = 0; t < 60; t++) begin
         logic [63:0] m = {$urandom, $urandom};
         if (t % 7 == 0) m = '0;
         run_txn(int'($urandom % 240), {$urandom, $urandom}, m, ($urandom % 10) == 0);
      end
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fails++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule